// File: doc/BRIEF.md
# Temperature Trip Comparator with Hysteresis

The block watches a stream of temperature samples and compares each accepted sample with three programmable limits: an upper alarm limit, a lower alarm limit and a critical limit. It keeps three sticky status flags: above-window, below-window and above-critical. Each flag sets as soon as a sample crosses its limit. It releases only once the temperature has moved back past that limit by a programmable hysteresis band. An active-low event pin is pulled low while any flag is set.

Software reaches the block through a simple write port with four word addresses: configuration, upper limit, lower limit and critical limit. The configuration word selects the hysteresis band and a shutdown mode. It also holds two lock bits that freeze the alarm-window limits and the critical limit. Once a lock bit is set, it stays set until reset. Temperatures are 13-bit two's-complement numbers, with 1/16 °C per LSB.

A small controller with two states decides whether samples are evaluated. In `ST_SENSE`, every valid sample updates the flags. In `ST_SLEEP`, samples are ignored. The transition SENSE→SLEEP is taken on the clock edge after the shutdown bit is seen set. The transition SLEEP→SENSE is taken on the edge after it is seen clear. In all other cases the state holds.

Top module: `temp_trip_cmp`

## Requirements
- R1: After reset all three flags are 0, the event pin is 1, every limit register is 0 and the configuration word is 0.
- R2: With the block sensing, a valid sample greater than or equal to the upper limit (address 1) sets the above-window flag on that clock edge.
- R3: A set upper-side flag clears only on a sample strictly below its limit minus the hysteresis. Configuration bits 10:9 choose the hysteresis: 00 gives 0, 01 gives 24 LSB (1.5 °C), 10 gives 48 LSB (3 °C) and 11 gives 96 LSB (6 °C).
- R4: A valid sample strictly below the lower limit (address 2) sets the below-window flag. That flag clears only on a sample at or above the lower limit plus the hysteresis.
- R5: The above-critical flag follows the critical limit (address 3) with the same set and release rules as the above-window flag.
- R6: When configuration bit 6 is 1, writes to addresses 1 and 2 are ignored. Once written to 1, bit 6 stays 1 until reset.
- R7: When configuration bit 7 is 1, writes to address 3 are ignored. Once written to 1, bit 7 stays 1 until reset.
- R8: When configuration bit 8 is 1, the block enters the sleep state one cycle later. In that state valid samples are ignored and all flags hold. Clearing bit 8 resumes sensing.
- R9: The event pin is 0 whenever any flag is set and 1 otherwise.
- R10: Samples and limits are compared as signed 13-bit values, so negative temperatures order correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 configuration, 1 upper, 2 lower, 3 critical |
| wr_data | input | 16 | Write data; limits take bits 12:0 |
| smp_valid | input | 1 | Temperature sample strobe |
| smp_temp | input | 13 | Signed temperature sample, 1/16 °C per LSB |
| flag_high | output | 1 | Above-window status |
| flag_low | output | 1 | Below-window status |
| flag_crit | output | 1 | Above-critical status |
| event_n | output | 1 | Active-low event, low while any flag is set |

## Verification
The upper side is tested with four kinds of sample. A sample just under the limit and a sample exactly at it separate `>=` from `>`. For each hysteresis code there is a sample one LSB above the release threshold and a sample exactly at it, which separate a correct band from a wrong one or from a strict/non-strict slip. On the lower side, the samples just inside and exactly at the release threshold check the mirrored rule, and negative limits check that the comparison is signed. Writes made while a lock is set, and samples sent while in sleep, are each followed by samples that would trip under the altered value. This shows at the flag pins whether the write or the sample leaked through.

// File: rtl/temp_trip_pkg.sv
package temp_trip_pkg;

    typedef enum logic [1:0] {
        ADDR_CFG  = 2'd0,
        ADDR_HIGH = 2'd1,
        ADDR_LOW  = 2'd2,
        ADDR_CRIT = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_SENSE = 1'b0,
        ST_SLEEP = 1'b1
    } ctl_state_e;

    localparam int CFG_LOCK_WIN_BIT  = 6;
    localparam int CFG_LOCK_CRIT_BIT = 7;
    localparam int CFG_SLEEP_BIT     = 8;
    localparam int CFG_HYST_LO_BIT   = 9;

    localparam int NUM_TRIPS = 3;
    localparam int TRIP_HIGH = 0;
    localparam int TRIP_LOW  = 1;
    localparam int TRIP_CRIT = 2;

    typedef struct packed {
        logic [1:0] hyst_code;
        logic       sleep_req;
        logic       lock_crit;
        logic       lock_win;
    } trip_cfg_t;

    // Hysteresis band in LSB: code 0 -> 0, then 1.5, 3, 6 degrees.
    function automatic int hyst_lsb(input logic [1:0] code, input int frac_bits);
        int base;
        base = 3 << (frac_bits - 1);
        if (code == 2'd0) return 0;
        return base << (int'(code) - 1);
    endfunction

endpackage

// File: rtl/temp_trip_regs.sv
module temp_trip_regs
    import temp_trip_pkg::*;
#(
    parameter int TW = 13,
    parameter int DW = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [1:0]                     wr_addr,
    input  logic [DW-1:0]                  wr_data,
    output trip_cfg_t                      cfg,
    output logic [NUM_TRIPS-1:0][TW-1:0]   limits
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= '0;
            limits <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_CFG: begin
                    cfg.hyst_code <= wr_data[CFG_HYST_LO_BIT+1:CFG_HYST_LO_BIT];
                    cfg.sleep_req <= wr_data[CFG_SLEEP_BIT];
                    cfg.lock_win  <= cfg.lock_win  | wr_data[CFG_LOCK_WIN_BIT];
                    cfg.lock_crit <= cfg.lock_crit | wr_data[CFG_LOCK_CRIT_BIT];
                end
                ADDR_HIGH: if (!cfg.lock_win)  limits[TRIP_HIGH] <= wr_data[TW-1:0];
                ADDR_LOW:  if (!cfg.lock_win)  limits[TRIP_LOW]  <= wr_data[TW-1:0];
                ADDR_CRIT: if (!cfg.lock_crit) limits[TRIP_CRIT] <= wr_data[TW-1:0];
            endcase
        end
    end

endmodule

// File: rtl/temp_trip_flag.sv
module temp_trip_flag #(
    parameter int TW       = 13,
    parameter int HW       = 8,
    parameter bit UPPER    = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] limit,
    input  logic [HW-1:0] hyst,
    output logic          flag
);

    localparam int XW = TW + 2;

    logic signed [XW-1:0] t_x;
    logic signed [XW-1:0] lim_x;
    logic signed [XW-1:0] h_x;
    logic signed [XW-1:0] release_thr;
    logic                 trip_hit;
    logic                 release_hit;

    assign t_x   = $signed({{2{temp[TW-1]}}, temp});
    assign lim_x = $signed({{2{limit[TW-1]}}, limit});
    assign h_x   = $signed({{(XW-HW){1'b0}}, hyst});

    generate
        if (UPPER) begin : g_upper
            assign release_thr = lim_x - h_x;
            assign trip_hit    = (t_x >= lim_x);
            assign release_hit = (t_x < release_thr);
        end else begin : g_lower
            assign release_thr = lim_x + h_x;
            assign trip_hit    = (t_x < lim_x);
            assign release_hit = (t_x >= release_thr);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (eval) begin
            if (!flag) flag <= trip_hit;
            else if (release_hit) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/temp_trip_cmp.sv
module temp_trip_cmp
    import temp_trip_pkg::*;
#(
    parameter int TW   = 13,
    parameter int DW   = 16,
    parameter int FRAC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    output logic          flag_high,
    output logic          flag_low,
    output logic          flag_crit,
    output logic          event_n
);

    localparam int HW = FRAC + 4;

    trip_cfg_t                    cfg;
    logic [NUM_TRIPS-1:0][TW-1:0] limits;
    logic [NUM_TRIPS-1:0]         flags;
    logic [HW-1:0]                hyst_amt;
    ctl_state_e                   state_q, state_d;
    logic                         eval;
    logic                         sleeping;
    logic                         lock_win;
    logic                         lock_crit;
    logic [TW-1:0]                lim_high;
    logic [TW-1:0]                lim_low;
    logic [TW-1:0]                lim_crit;

    temp_trip_regs #(.TW(TW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .limits  (limits)
    );

    assign hyst_amt  = HW'(hyst_lsb(cfg.hyst_code, FRAC));
    assign lock_win  = cfg.lock_win;
    assign lock_crit = cfg.lock_crit;
    assign lim_high  = limits[TRIP_HIGH];
    assign lim_low   = limits[TRIP_LOW];
    assign lim_crit  = limits[TRIP_CRIT];

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SENSE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SENSE: if (cfg.sleep_req)  state_d = ST_SLEEP;
            ST_SLEEP: if (!cfg.sleep_req) state_d = ST_SENSE;
        endcase
    end

    // Controller: outputs
    always_comb begin
        eval     = 1'b0;
        sleeping = 1'b0;
        unique case (state_q)
            ST_SENSE: eval     = smp_valid;
            ST_SLEEP: sleeping = 1'b1;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_TRIPS; gi++) begin : g_trip
            temp_trip_flag #(
                .TW    (TW),
                .HW    (HW),
                .UPPER (gi != TRIP_LOW)
            ) u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .eval  (eval),
                .temp  (smp_temp),
                .limit (limits[gi]),
                .hyst  (hyst_amt),
                .flag  (flags[gi])
            );
        end
    endgenerate

    assign flag_high = flags[TRIP_HIGH];
    assign flag_low  = flags[TRIP_LOW];
    assign flag_crit = flags[TRIP_CRIT];
    assign event_n   = ~|flags;

endmodule

// File: rtl/temp_trip_chk.sv
module temp_trip_chk #(
    parameter int TW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic          smp_valid,
    input logic [TW-1:0] smp_temp,
    input logic          sleeping,
    input logic          lock_win,
    input logic          lock_crit,
    input logic [TW-1:0] lim_high,
    input logic [TW-1:0] lim_low,
    input logic [TW-1:0] lim_crit,
    input logic          flag_high,
    input logic          flag_low,
    input logic          flag_crit
);

    p_trip_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !sleeping && ($signed(smp_temp) >= $signed(lim_high))) |=> flag_high);

    p_trip_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !sleeping && ($signed(smp_temp) < $signed(lim_low))) |=> flag_low);

    p_trip_crit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !sleeping && ($signed(smp_temp) >= $signed(lim_crit))) |=> flag_crit);

    p_lock_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_win && wr_en && wr_addr == 2'd1) |=> $stable(lim_high));

    p_lock_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_win && wr_en && wr_addr == 2'd2) |=> $stable(lim_low));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_win |=> lock_win);

    p_lock_crit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_crit && wr_en && wr_addr == 2'd3) |=> $stable(lim_crit));

    p_lock_crit_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_crit |=> lock_crit);

    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping || !smp_valid) |=> ($stable(flag_high) && $stable(flag_low) && $stable(flag_crit)));

endmodule

bind temp_trip_cmp temp_trip_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .smp_valid (smp_valid),
    .smp_temp  (smp_temp),
    .sleeping  (sleeping),
    .lock_win  (lock_win),
    .lock_crit (lock_crit),
    .lim_high  (lim_high),
    .lim_low   (lim_low),
    .lim_crit  (lim_crit),
    .flag_high (flag_high),
    .flag_low  (flag_low),
    .flag_crit (flag_crit)
);

// File: tb/tb_temp_trip_cmp.sv
module tb_temp_trip_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        flag_high, flag_low, flag_crit, event_n;

    int checks = 0;
    int errors = 0;

    // model state
    int m_up = 0, m_lo = 0, m_cr = 0, m_hyst = 0;
    bit m_lockw = 0, m_lockc = 0, m_sleep = 0;
    bit m_fh = 0, m_fl = 0, m_fc = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    temp_trip_cmp dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .flag_high(flag_high), .flag_low(flag_low), .flag_crit(flag_crit),
        .event_n(event_n)
    );

    task automatic write_reg(input int a, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = v[15:0];
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            0: begin
                m_hyst  = (v >> 9) & 3;
                m_sleep = v[8];
                m_lockw = m_lockw | v[6];
                m_lockc = m_lockc | v[7];
            end
            1: if (!m_lockw) m_up = v;
            2: if (!m_lockw) m_lo = v;
            default: if (!m_lockc) m_cr = v;
        endcase
        repeat (2) @(negedge clk);
    endtask

    function automatic int band(input int code);
        return (code == 0) ? 0 : (24 << (code - 1));
    endfunction

    task automatic send_sample(input int t, input string tag);
        int h;
        h = band(m_hyst);
        if (!m_sleep) begin
            if (!m_fh) m_fh = (t >= m_up); else if (t < m_up - h) m_fh = 0;
            if (!m_fc) m_fc = (t >= m_cr); else if (t < m_cr - h) m_fc = 0;
            if (!m_fl) m_fl = (t < m_lo);  else if (t >= m_lo + h) m_fl = 0;
        end
        exp_q.push_back({m_fc, m_fl, m_fh});
        tag_q.push_back(tag);
        @(negedge clk);
        smp_valid = 1'b1; smp_temp = t[12:0];
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // monitor / scoreboard
    initial begin
        logic [2:0] e;
        string      tg;
        forever begin
            @(posedge clk);
            if (smp_valid) begin
                @(negedge clk);
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({flag_crit, flag_low, flag_high} !== e) begin
                    errors++;
                    $display("FAIL %s flags crit/low/high got %b exp %b", tg,
                             {flag_crit, flag_low, flag_high}, e);
                end
                checks++;
                if (event_n !== ~|e) begin
                    errors++;
                    $display("FAIL R9 event_n got %b exp %b", event_n, ~|e);
                end
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({flag_crit, flag_low, flag_high, event_n} !== 4'b0001) begin
            errors++;
            $display("FAIL R1 reset outputs got %b exp 0001",
                     {flag_crit, flag_low, flag_high, event_n});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: limits reset to 0, so a zero sample trips upper and critical
        send_sample(0, "R1");
        send_sample(-1, "R1");

        write_reg(1, 400); write_reg(2, 160); write_reg(3, 800);
        send_sample(320, "R2");
        send_sample(399, "R2");
        send_sample(400, "R2");
        send_sample(399, "R3");           // hyst 0 release
        write_reg(0, 3 << 9);             // 96 LSB
        send_sample(400, "R3");
        send_sample(305, "R3");
        send_sample(304, "R3");
        send_sample(303, "R3");
        write_reg(0, 1 << 9);             // 24 LSB
        send_sample(401, "R3");
        send_sample(376, "R3");
        send_sample(375, "R3");
        write_reg(0, 2 << 9);             // 48 LSB
        send_sample(400, "R3");
        send_sample(352, "R3");
        send_sample(351, "R3");
        send_sample(160, "R4");
        send_sample(159, "R4");
        send_sample(207, "R4");
        send_sample(208, "R4");
        send_sample(799, "R5");
        send_sample(800, "R5");
        send_sample(752, "R5");
        send_sample(751, "R5");
        send_sample(300, "R3");
        write_reg(2, -160);
        send_sample(-160, "R10");
        send_sample(-161, "R10");
        send_sample(-113, "R10");
        send_sample(-112, "R10");
        // R6 window lock
        write_reg(0, 1 << 6);
        write_reg(1, 100);
        write_reg(2, 500);
        send_sample(200, "R6");
        write_reg(0, 0);                  // try to clear lock
        write_reg(1, 100);
        send_sample(200, "R6");
        send_sample(400, "R6");
        send_sample(0, "R6");
        // R7 critical lock
        write_reg(0, (1 << 6) | (1 << 7));
        write_reg(3, 100);
        send_sample(399, "R7");
        write_reg(0, 1 << 6);
        write_reg(3, 100);
        send_sample(799, "R7");
        send_sample(800, "R7");
        send_sample(0, "R7");
        // R8 shutdown
        send_sample(500, "R8");
        write_reg(0, 1 << 8);
        send_sample(0, "R8");
        send_sample(900, "R8");
        send_sample(-500, "R8");
        write_reg(0, 0);
        send_sample(0, "R8");
        send_sample(-500, "R8");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule